// File: doc/BRIEF.md
# Peripheral Reset and Clock-Gate Controller

This block owns the reset lines and clock enables of a group of up to 32 peripherals. Software sets or clears one bit per peripheral in a request register over a simple 32-bit register bus. A cleared bit holds that peripheral in reset with its clock gated. A set bit releases it and lets its clock run. A second copy of the request, the clock request, always carries the same value. A write to either copy updates both.

Each peripheral answers with a reset acknowledge and a clock acknowledge. The block passes each acknowledge through a two-flop synchroniser. It then requires the acknowledge to stay stable for a configurable number of cycles before the matching status bit changes. A per-line completion flag rises only when both status bits agree with the request. A line mask parameter removes lines that do not exist. A build option drops the clock side entirely, which leaves a request register and a status register.

Top module: `prc_ctrl`

## Requirements
- R1: After a synchronous reset, every request bit and every status bit reads 0, all `rst_n_o` and `clk_en_o` bits are 0, and `done_o` equals the valid-line mask.
- R2: A write to offset 0x0 or offset 0xC loads the same masked value into both the reset request and the clock request. Reading either offset afterwards returns that value.
- R3: Line i exists only if bit i of VALID_MASK is 1. For any other line, written bits are dropped and the request and status bits read 0. Its `rst_n_o`, `clk_en_o` and `done_o` stay 0, and its acknowledge inputs are ignored.
- R4: `rst_n_o[i]` equals reset request bit i and `clk_en_o[i]` equals clock request bit i. A value of 0 means in reset or gated. The outputs take a new value on the clock edge that accepts the write.
- R5: A status bit equals the acknowledge input seen through two flops and then held stable for SETTLE_CYCLES cycles. A clean level change on an acknowledge shows up in the status bit at the (SETTLE_CYCLES+2)-th rising edge after the change.
- R6: An acknowledge pulse that lasts fewer than SETTLE_CYCLES cycles leaves the status bit unchanged. A pulse of SETTLE_CYCLES cycles or longer reaches it.
- R7: `done_o[i]` is 1 only while the reset status bit equals the reset request bit and the clock status bit equals the clock request bit for line i.
- R8: Writes to the status offsets 0x4 and 0x8 change neither the request registers nor the outputs.
- R9: A read with `reg_en`=1 and `reg_we`=0 returns data on `reg_rdata` with `reg_rvalid`=1 on the following cycle. The register offsets are: 0x0 reset request, 0x4 clock status, 0x8 reset status, 0xC clock request. Any other address reads 0.
- R10: With HAS_CLOCK=0, offset 0x0 is the request and offset 0x4 is the reset status. Offsets 0x8 and 0xC read 0 and ignore writes, `clk_en_o` stays 0, and `done_o` depends only on the reset status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| rst_n_o | output | NUM_LINES | Per-line active-low reset |
| clk_en_o | output | NUM_LINES | Per-line clock enable |
| rst_ack_i | input | NUM_LINES | Per-line reset acknowledge (1 = released) |
| clk_ack_i | input | NUM_LINES | Per-line clock acknowledge (1 = running) |
| done_o | output | NUM_LINES | Per-line completion: both statuses match the request |

## Verification
The bench builds two instances. The first has 32 lines, mask 0x1F7F and a settling window of 4. This leaves a hole at line 7 and the upper lines absent. With a window of 4, a 3-cycle acknowledge glitch can be told apart from a 4-cycle pulse, and the 6-edge status latency can be checked cycle by cycle. The second instance has no clock side, mask 0xFF and a window of 2. It covers the reduced register map, the 4-edge latency and the clock enables held at zero.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        SEL_RST_REQ  = 3'd0,
        SEL_CLK_STAT = 3'd1,
        SEL_RST_STAT = 3'd2,
        SEL_CLK_REQ  = 3'd3,
        SEL_NONE     = 3'd4
    } prc_sel_e;

    typedef struct packed {
        logic             en;
        logic             we;
        prc_sel_e         sel;
        logic [BUS_W-1:0] wdata;
    } prc_bus_req_t;

    // Map a byte address onto a register; the reduced map has no clock side.
    function automatic prc_sel_e prc_decode(input logic [ADDR_W-1:0] addr,
                                            input logic has_clock);
        prc_sel_e sel;
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (has_clock) begin
                sel = prc_sel_e'({1'b0, addr[3:2]});
            end else begin
                case (addr[3:2])
                    2'd0:    sel = SEL_RST_REQ;
                    2'd1:    sel = SEL_RST_STAT;
                    default: sel = SEL_NONE;
                endcase
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/prc_settle.sv
module prc_settle #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_i,
    output logic stat_o
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cnt_q  <= '0;
            stat_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ack_i};
            if (sync_q[1] != stat_o) begin
                if (cnt_q == LAST) begin
                    stat_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/prc_line.sv
module prc_line #(
    parameter int SETTLE_CYCLES = 4,
    parameter int HAS_CLOCK     = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_ack_i,
    input  logic clk_ack_i,
    output logic rst_stat_o,
    output logic clk_stat_o
);
    prc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_rst_side (
        .clk    (clk),
        .rst    (rst),
        .ack_i  (rst_ack_i),
        .stat_o (rst_stat_o)
    );

    generate
        if (HAS_CLOCK != 0) begin : g_clk_side
            prc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_clk_side (
                .clk    (clk),
                .rst    (rst),
                .ack_i  (clk_ack_i),
                .stat_o (clk_stat_o)
            );
        end else begin : g_no_clk_side
            assign clk_stat_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/prc_regs.sv
module prc_regs
    import prc_pkg::*;
#(
    parameter int                   NUM_LINES  = 32,
    parameter logic [NUM_LINES-1:0] VALID_MASK = '1,
    parameter int                   HAS_CLOCK  = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  prc_bus_req_t         bus_i,
    input  logic [NUM_LINES-1:0] rst_stat_i,
    input  logic [NUM_LINES-1:0] clk_stat_i,
    output logic [NUM_LINES-1:0] rst_req_o,
    output logic [NUM_LINES-1:0] clk_req_o,
    output logic [BUS_W-1:0]     rdata_o,
    output logic                 rvalid_o
);
    logic                 req_wr;
    logic [NUM_LINES-1:0] req_val;
    logic [BUS_W-1:0]     rd_next;

    assign req_wr  = bus_i.en && bus_i.we &&
                     (bus_i.sel == SEL_RST_REQ || bus_i.sel == SEL_CLK_REQ);
    assign req_val = bus_i.wdata[NUM_LINES-1:0] & VALID_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_o <= '0;
        end else if (req_wr) begin
            rst_req_o <= req_val;
        end
    end

    generate
        if (HAS_CLOCK != 0) begin : g_clk_req
            always_ff @(posedge clk) begin
                if (rst) begin
                    clk_req_o <= '0;
                end else if (req_wr) begin
                    clk_req_o <= req_val;
                end
            end
        end else begin : g_no_clk_req
            assign clk_req_o = '0;
        end
    endgenerate

    always_comb begin
        case (bus_i.sel)
            SEL_RST_REQ:  rd_next = BUS_W'(rst_req_o);
            SEL_CLK_REQ:  rd_next = BUS_W'(clk_req_o);
            SEL_RST_STAT: rd_next = BUS_W'(rst_stat_i & VALID_MASK);
            SEL_CLK_STAT: rd_next = BUS_W'(clk_stat_i & VALID_MASK);
            default:      rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= bus_i.en && !bus_i.we;
            if (bus_i.en && !bus_i.we) begin
                rdata_o <= rd_next;
            end
        end
    end
endmodule

// File: rtl/prc_ctrl.sv
module prc_ctrl
    import prc_pkg::*;
#(
    parameter int                   NUM_LINES     = 32,
    parameter logic [NUM_LINES-1:0] VALID_MASK    = 32'h0000_1F7F,
    parameter int                   SETTLE_CYCLES = 4,
    parameter int                   HAS_CLOCK     = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_rvalid,
    output logic [NUM_LINES-1:0] rst_n_o,
    output logic [NUM_LINES-1:0] clk_en_o,
    input  logic [NUM_LINES-1:0] rst_ack_i,
    input  logic [NUM_LINES-1:0] clk_ack_i,
    output logic [NUM_LINES-1:0] done_o
);
    prc_bus_req_t         bus;
    logic [NUM_LINES-1:0] rst_req;
    logic [NUM_LINES-1:0] clk_req;
    logic [NUM_LINES-1:0] rst_stat;
    logic [NUM_LINES-1:0] clk_stat;

    assign bus.en    = reg_en;
    assign bus.we    = reg_we;
    assign bus.sel   = prc_decode(reg_addr, HAS_CLOCK != 0);
    assign bus.wdata = reg_wdata;

    prc_regs #(
        .NUM_LINES  (NUM_LINES),
        .VALID_MASK (VALID_MASK),
        .HAS_CLOCK  (HAS_CLOCK)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_i      (bus),
        .rst_stat_i (rst_stat),
        .clk_stat_i (clk_stat),
        .rst_req_o  (rst_req),
        .clk_req_o  (clk_req),
        .rdata_o    (reg_rdata),
        .rvalid_o   (reg_rvalid)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (VALID_MASK[i]) begin : g_present
            prc_line #(
                .SETTLE_CYCLES (SETTLE_CYCLES),
                .HAS_CLOCK     (HAS_CLOCK)
            ) u_line (
                .clk        (clk),
                .rst        (rst),
                .rst_ack_i  (rst_ack_i[i]),
                .clk_ack_i  (clk_ack_i[i]),
                .rst_stat_o (rst_stat[i]),
                .clk_stat_o (clk_stat[i])
            );
        end else begin : g_hole
            assign rst_stat[i] = 1'b0;
            assign clk_stat[i] = 1'b0;
        end
    end

    assign rst_n_o  = rst_req;
    assign clk_en_o = clk_req;
    assign done_o   = VALID_MASK & ~(rst_stat ^ rst_req) & ~(clk_stat ^ clk_req);
endmodule

// File: rtl/prc_ctrl_chk.sv
module prc_ctrl_chk #(
    parameter int                   NUM_LINES  = 32,
    parameter logic [NUM_LINES-1:0] VALID_MASK = '1,
    parameter int                   HAS_CLOCK  = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_en,
    input logic                 reg_we,
    input logic [3:0]           reg_addr,
    input logic [31:0]          reg_wdata,
    input logic                 reg_rvalid,
    input logic [NUM_LINES-1:0] rst_n_o,
    input logic [NUM_LINES-1:0] clk_en_o,
    input logic [NUM_LINES-1:0] done_o
);
    logic wr_req;
    assign wr_req = reg_en && reg_we &&
                    (reg_addr == 4'h0 || (HAS_CLOCK != 0 && reg_addr == 4'hC));

    assert_absent_lines_R3: assert property (@(posedge clk) disable iff (rst)
        ((rst_n_o | clk_en_o | done_o) & ~VALID_MASK) == '0);

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> (rst_n_o == ($past(reg_wdata[NUM_LINES-1:0]) & VALID_MASK)));

    assert_no_stray_change_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> $stable(rst_n_o));

    assert_read_answers_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_we) |=> reg_rvalid);

    assert_no_idle_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && !reg_we) |=> !reg_rvalid);

    generate
        if (HAS_CLOCK != 0) begin : g_clk_chk
            assert_lockstep_R2: assert property (@(posedge clk) disable iff (rst)
                rst_n_o == clk_en_o);
        end else begin : g_noclk_chk
            assert_clock_idle_R10: assert property (@(posedge clk) disable iff (rst)
                clk_en_o == '0);
        end
    endgenerate
endmodule

bind prc_ctrl prc_ctrl_chk #(
    .NUM_LINES  (NUM_LINES),
    .VALID_MASK (VALID_MASK),
    .HAS_CLOCK  (HAS_CLOCK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .rst_n_o    (rst_n_o),
    .clk_en_o   (clk_en_o),
    .done_o     (done_o)
);

// File: tb/sim_prc_ctrl.sv
module sim_prc_ctrl;
    localparam logic [31:0] M0 = 32'h0000_1F7F;
    localparam logic [31:0] M1 = 32'h0000_00FF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        en0 = 0, we0 = 0, en1 = 0, we1 = 0;
    logic [3:0]  ad0 = 0, ad1 = 0;
    logic [31:0] wd0 = 0, wd1 = 0;
    logic [31:0] rd0, rd1;
    logic        rv0, rv1;
    logic [31:0] rn0, ce0, dn0, ra0 = 0, ca0 = 0;
    logic [31:0] rn1, ce1, dn1, ra1 = 0;
    logic [31:0] ca1 = 0;

    int checks = 0;
    int bad = 0;

    logic [31:0] q0_exp[$], q1_exp[$];
    string       q0_tag[$], q1_tag[$];

    prc_ctrl #(.NUM_LINES(32), .VALID_MASK(M0), .SETTLE_CYCLES(4), .HAS_CLOCK(1)) u0 (
        .clk(clk), .rst(rst), .reg_en(en0), .reg_we(we0), .reg_addr(ad0),
        .reg_wdata(wd0), .reg_rdata(rd0), .reg_rvalid(rv0), .rst_n_o(rn0),
        .clk_en_o(ce0), .rst_ack_i(ra0), .clk_ack_i(ca0), .done_o(dn0));

    prc_ctrl #(.NUM_LINES(32), .VALID_MASK(M1), .SETTLE_CYCLES(2), .HAS_CLOCK(0)) u1 (
        .clk(clk), .rst(rst), .reg_en(en1), .reg_we(we1), .reg_addr(ad1),
        .reg_wdata(wd1), .reg_rdata(rd1), .reg_rvalid(rv1), .rst_n_o(rn1),
        .clk_en_o(ce1), .rst_ack_i(ra1), .clk_ack_i(ca1), .done_o(dn1));

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (which == 0) begin en0 = 1; we0 = 1; ad0 = a; wd0 = d; end
        else            begin en1 = 1; we1 = 1; ad1 = a; wd1 = d; end
        @(negedge clk);
        en0 = 0; we0 = 0; en1 = 0; we1 = 0;
    endtask

    task automatic rd(input int which, input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        if (which == 0) begin en0 = 1; we0 = 0; ad0 = a; q0_exp.push_back(exp); q0_tag.push_back(tag); end
        else            begin en1 = 1; we1 = 0; ad1 = a; q1_exp.push_back(exp); q1_tag.push_back(tag); end
        @(negedge clk);
        en0 = 0; en1 = 0;
    endtask

    // Monitors: pop the expected read data when the design presents it.
    always @(negedge clk) begin
        if (!rst && rv0) begin
            if (q0_exp.size() == 0) check_eq("R9 unexpected rvalid u0", rd0, 32'hx);
            else check_eq(q0_tag.pop_front(), rd0, q0_exp.pop_front());
        end
        if (!rst && rv1) begin
            if (q1_exp.size() == 0) check_eq("R9 unexpected rvalid u1", rd1, 32'hx);
            else check_eq(q1_tag.pop_front(), rd1, q1_exp.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check_eq("watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 rst_n_o", rn0, 32'h0);
        check_eq("R1 clk_en_o", ce0, 32'h0);
        check_eq("R1 done_o", dn0, M0);
        rd(0, 4'h0, 32'h0, "R1 reset request");
        rd(0, 4'h4, 32'h0, "R1 clock status");
        rd(0, 4'h8, 32'h0, "R1 reset status");
        rd(0, 4'hC, 32'h0, "R1 clock request");

        // R4 R2 R3: release everything, mask applied to both copies
        wr(0, 4'h0, 32'hFFFF_FFFF);
        check_eq("R4 rst_n_o after write", rn0, M0);
        check_eq("R2 clk_en_o lockstep", ce0, M0);
        check_eq("R7 done low before ack", dn0, 32'h0);
        rd(0, 4'hC, M0, "R2 clock request copy");

        // R5 exact latency: status at edge SETTLE+2 = 6
        @(negedge clk);
        ra0 = 32'hFFFF_FFFF; ca0 = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        check_eq("R5 status not yet settled", dn0, 32'h0);
        @(negedge clk);
        check_eq("R5 status settled at edge 6", dn0, M0);
        rd(0, 4'h8, M0, "R3 reset status masked");
        rd(0, 4'h4, M0, "R3 clock status masked");

        // R7 partial completion
        wr(0, 4'h0, 32'h1);
        check_eq("R7 done after request drop", dn0, 32'h1);
        @(negedge clk);
        ra0 = 32'h1;
        repeat (10) @(negedge clk);
        check_eq("R7 done needs clock side", dn0, 32'h1);
        rd(0, 4'h8, 32'h1, "R9 reset status offset");
        rd(0, 4'h4, M0, "R9 clock status offset");
        @(negedge clk);
        ca0 = 32'h1;
        repeat (10) @(negedge clk);
        check_eq("R7 done both sides", dn0, M0);

        // R6 glitch of 3 cycles rejected
        ra0 = 32'h5;
        repeat (3) @(negedge clk);
        ra0 = 32'h1;
        repeat (10) @(negedge clk);
        check_eq("R6 short pulse ignored", dn0, M0);
        rd(0, 4'h8, 32'h1, "R6 status after short pulse");
        // 4-cycle pulse reaches the status
        ra0 = 32'h5;
        repeat (4) @(negedge clk);
        ra0 = 32'h1;
        repeat (2) @(negedge clk);
        check_eq("R6 long pulse seen", dn0, M0 & ~32'h4);
        repeat (10) @(negedge clk);
        check_eq("R6 long pulse recovers", dn0, M0);

        // R8 writes to status offsets ignored
        wr(0, 4'h8, 32'hFFFF_FFFF);
        wr(0, 4'h4, 32'h0);
        check_eq("R8 rst_n_o unchanged", rn0, 32'h1);
        check_eq("R8 done unchanged", dn0, M0);
        rd(0, 4'h0, 32'h1, "R8 request unchanged");

        // R2 write via clock request offset
        wr(0, 4'hC, M0);
        check_eq("R2 rst_n_o via 0xC", rn0, M0);
        check_eq("R2 clk_en_o via 0xC", ce0, M0);
        rd(0, 4'h0, M0, "R2 reset request via 0xC");

        // R3 only absent bits written
        wr(0, 4'h0, 32'hFFFF_E080);
        check_eq("R3 rst_n_o absent bits", rn0, 32'h0);
        check_eq("R3 clk_en_o absent bits", ce0, 32'h0);
        rd(0, 4'hC, 32'h0, "R3 clock request absent bits");
        rd(0, 4'h2, 32'h0, "R9 unaligned address");

        // R10 reduced variant
        rd(1, 4'h0, 32'h0, "R10 reset state");
        wr(1, 4'h0, 32'hFFFF);
        check_eq("R10 rst_n_o", rn1, M1);
        check_eq("R10 clk_en_o idle", ce1, 32'h0);
        check_eq("R10 done low", dn1, 32'h0);
        @(negedge clk);
        ra1 = 32'hFF;
        repeat (3) @(negedge clk);
        check_eq("R5 variant not yet settled", dn1, 32'h0);
        @(negedge clk);
        check_eq("R5 variant settled at edge 4", dn1, M1);
        rd(1, 4'h4, M1, "R10 status at 0x4");
        rd(1, 4'h8, 32'h0, "R10 0x8 reads 0");
        rd(1, 4'hC, 32'h0, "R10 0xC reads 0");
        wr(1, 4'hC, 32'h0);
        check_eq("R10 0xC write ignored", rn1, M1);

        repeat (4) @(negedge clk);
        check_eq("R9 all reads answered", 32'(q0_exp.size() + q1_exp.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule